// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and calendar date as seven packed-BCD bytes. Each byte has the tens digit in the upper nibble and the units digit in the lower nibble. The seven bytes hold seconds, minutes, hours, weekday, day of month, month and two-digit year. A base tick from an upstream prescaler feeds an internal sub-second phase counter. Every `SUB_TICKS` base ticks, the phase counter advances the seconds. The carry then ripples through the whole calendar in the same clock cycle, with month lengths and leap years taken into account.

A bus interface reaches the registers through a byte-wide port. A write stores the field directly, and unused bits are cleared. A read of the addressed register is combinational. The seconds register also carries a halt flag. While the flag is set, both the phase counter and the calendar are frozen, and the flag is driven out to the prescaler. The hours register selects 12-hour or 24-hour counting. In 12-hour form, one bit of that register is the afternoon flag. In 24-hour form, the same bit is the upper bit of the tens digit.

Top module: `bcd_calendar`

## Requirements
- R1: After reset, registers 0..6 read 00, 00, 00, 01, 01, 01, 00 (24-hour mode, running), and `halted` is 0.
- R2: A write to register a (0..6) stores wdata masked to the used bits. The masks are 0:FF, 1:7F, 2:7F, 3:07, 4:3F, 5:1F, 6:FF. Address 7 reads 00, and rdata always shows the addressed register.
- R3: Seconds (register 0, bits 6:0) advance by one BCD step once every SUB_TICKS accepted ticks, and wrap from 59 to 00 with a carry into minutes.
- R4: While bit 7 of register 0 is 1, ticks have no effect and `halted` is 1. When it is cleared, counting resumes.
- R5: Minutes wrap from 59 to 00 and carry into hours.
- R6: With register 2 bit 6 at 0 (24-hour), hours run 00..23 in bits 5:0, and 23 wraps to 00 with a carry into the date.
- R7: With register 2 bit 6 at 1 (12-hour), hours run 01..12 in bits 4:0, and bit 5 is the PM flag. 11 steps to 12 and toggles bit 5. 12 steps to 01 and keeps bit 5. Only 11 PM to 12 AM carries into the date.
- R8: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February, then carries into the month.
- R9: February ends at 29 when the BCD year is divisible by four, and at 28 otherwise.
- R10: On each date carry, the weekday (register 3) steps by one and wraps from 7 to 1.
- R11: The month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00.
- R12: In a cycle with wr_en high, the tick is ignored. A write to register 0 also resets the sub-second phase, so the next second needs a full SUB_TICKS ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Base tick from the prescaler, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register index for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Contents of the addressed register |
| halted | output | 1 | Copy of the halt flag, sent to the prescaler |

## Verification
The bench starts from the last second before each kind of rollover. It covers 23:59:59 in 24-hour form, and 11:59:59 AM/PM and 12:59:59 in 12-hour form. It also covers the last day of 30-day months, 31-day months and February in both leap and non-leap years, weekday 7, and 31 December of year 99. These cases catch a calendar that wraps a day late or early, toggles the PM flag on the wrong hour, or fails to carry into the next field. Writes that collide with the tick that would complete a second show whether writes really take priority. A seconds write after a partial phase shows whether the sub-second phase is cleared. Random boundary-heavy settings in both hour modes, with occasional halts, cross-check every register against a model that works in plain integers.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int unsigned NUM_REGS = 7;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] dow;
        logic [7:0] date;
        logic [7:0] mon;
        logic [7:0] yr;
    } cal_regs_t;

    // One BCD step upward; the caller handles the wrap of each field.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'h9)
            return {v[7:4] + 4'h1, 4'h0};
        else
            return v + 8'h01;
    endfunction

    function automatic logic [7:0] reg_mask(input logic [2:0] a);
        case (a)
            3'd0:    return 8'hFF;
            3'd1:    return 8'h7F;
            3'd2:    return 8'h7F;
            3'd3:    return 8'h07;
            3'd4:    return 8'h3F;
            3'd5:    return 8'h1F;
            3'd6:    return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cal_subsec.sv
module cal_subsec #(
    parameter int unsigned SUB_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    input  logic hold,
    input  logic clear,
    output logic sec_pulse
);
    logic advance;
    assign advance = run && tick && !hold;

    generate
        if (SUB_TICKS > 1) begin : g_count
            localparam int unsigned CW = $clog2(SUB_TICKS);
            localparam logic [CW-1:0] LAST = CW'(SUB_TICKS - 1);
            logic [CW-1:0] ph_d, ph_q;

            always_comb begin
                ph_d = ph_q;
                if (clear)
                    ph_d = '0;
                else if (advance)
                    ph_d = (ph_q == LAST) ? '0 : ph_q + 1'b1;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) ph_q <= '0;
                else        ph_q <= ph_d;
            end

            assign sec_pulse = advance && (ph_q == LAST);
        end else begin : g_direct
            assign sec_pulse = advance;
        end
    endgenerate
endmodule

// File: rtl/cal_hour_step.sv
module cal_hour_step
    import cal_pkg::*;
(
    input  logic       mode12,
    input  logic [5:0] hour_in,
    output logic [5:0] hour_out,
    output logic       day_carry
);
    logic [7:0] inc12, inc24;
    assign inc12 = bcd_inc({3'b000, hour_in[4:0]});
    assign inc24 = bcd_inc({2'b00, hour_in});

    always_comb begin
        hour_out  = hour_in;
        day_carry = 1'b0;
        if (mode12) begin
            if (hour_in[4:0] == 5'h12) begin
                hour_out = {hour_in[5], 5'h01};
            end else if (hour_in[4:0] == 5'h11) begin
                hour_out  = {~hour_in[5], 5'h12};
                day_carry = hour_in[5];
            end else begin
                hour_out = {hour_in[5], inc12[4:0]};
            end
        end else begin
            if (hour_in >= 6'h23) begin
                hour_out  = 6'h00;
                day_carry = 1'b1;
            end else begin
                hour_out = inc24[5:0];
            end
        end
    end
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len (
    input  logic [7:0] mon,
    input  logic [7:0] yr,
    output logic [7:0] last_date
);
    logic leap;
    always_comb begin
        if (yr[4])
            leap = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
        else
            leap = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    end

    always_comb begin
        case (mon)
            8'h02:                      last_date = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
            default:                    last_date = 8'h31;
        endcase
    end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import cal_pkg::*;
#(
    parameter int unsigned SUB_TICKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wr_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       halted
);
    localparam cal_regs_t RESET_VAL = '{
        sec: 8'h00, min: 8'h00, hour: 8'h00, dow: 8'h01,
        date: 8'h01, mon: 8'h01, yr: 8'h00
    };

    cal_regs_t  r_d, r_q;
    logic       sec_pulse;
    logic [5:0] hr_next;
    logic       hr_carry;
    logic [7:0] last_date;

    assign halted = r_q.sec[7];

    cal_subsec #(.SUB_TICKS(SUB_TICKS)) u_subsec (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .run       (!r_q.sec[7]),
        .hold      (wr_en),
        .clear     (wr_en && (addr == 3'd0)),
        .sec_pulse (sec_pulse)
    );

    cal_hour_step u_hour (
        .mode12    (r_q.hour[6]),
        .hour_in   (r_q.hour[5:0]),
        .hour_out  (hr_next),
        .day_carry (hr_carry)
    );

    cal_month_len u_mlen (
        .mon       (r_q.mon),
        .yr        (r_q.yr),
        .last_date (last_date)
    );

    always_comb begin
        logic c_min, c_hr, c_day, c_mon, c_yr;
        logic [7:0] wv;
        r_d   = r_q;
        c_min = 1'b0;
        c_hr  = 1'b0;
        c_day = 1'b0;
        c_mon = 1'b0;
        c_yr  = 1'b0;
        wv    = wdata & reg_mask(addr);
        if (wr_en) begin
            case (addr)
                3'd0:    r_d.sec  = wv;
                3'd1:    r_d.min  = wv;
                3'd2:    r_d.hour = wv;
                3'd3:    r_d.dow  = wv;
                3'd4:    r_d.date = wv;
                3'd5:    r_d.mon  = wv;
                3'd6:    r_d.yr   = wv;
                default: r_d = r_q;
            endcase
        end else if (sec_pulse) begin
            if (r_q.sec[6:0] >= 7'h59) begin
                r_d.sec = 8'h00;
                c_min   = 1'b1;
            end else begin
                r_d.sec = bcd_inc({1'b0, r_q.sec[6:0]});
            end
            if (c_min) begin
                if (r_q.min >= 8'h59) begin
                    r_d.min = 8'h00;
                    c_hr    = 1'b1;
                end else begin
                    r_d.min = bcd_inc(r_q.min);
                end
            end
            if (c_hr) begin
                r_d.hour = {1'b0, r_q.hour[6], hr_next};
                c_day    = hr_carry;
            end
            if (c_day) begin
                r_d.dow = (r_q.dow >= 8'h07) ? 8'h01 : r_q.dow + 8'h01;
                if (r_q.date >= last_date) begin
                    r_d.date = 8'h01;
                    c_mon    = 1'b1;
                end else begin
                    r_d.date = bcd_inc(r_q.date);
                end
            end
            if (c_mon) begin
                if (r_q.mon >= 8'h12) begin
                    r_d.mon = 8'h01;
                    c_yr    = 1'b1;
                end else begin
                    r_d.mon = bcd_inc(r_q.mon);
                end
            end
            if (c_yr)
                r_d.yr = (r_q.yr >= 8'h99) ? 8'h00 : bcd_inc(r_q.yr);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    always_comb begin
        case (addr)
            3'd0:    rdata = r_q.sec;
            3'd1:    rdata = r_q.min;
            3'd2:    rdata = r_q.hour;
            3'd3:    rdata = r_q.dow;
            3'd4:    rdata = r_q.date;
            3'd5:    rdata = r_q.mon;
            3'd6:    rdata = r_q.yr;
            default: rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/cal_checker.sv
module cal_checker
    import cal_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [2:0] addr,
    input logic [7:0] wdata,
    input logic       halted,
    input logic       sec_pulse,
    input cal_regs_t  st
);
    // R3: without a write or a second pulse the calendar holds.
    p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !sec_pulse) |=> (st == $past(st)));

    // R3: seconds at 59 wrap to 00 on a pulse.
    p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && !wr_en && st.sec[6:0] == 7'h59) |=> (st.sec[6:0] == 7'h00));

    // R4: the phase counter never fires while halted.
    p_halt_no_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !sec_pulse);

    // R2: a month write stores the masked byte.
    p_write_month_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd5) |=> (st.mon == ($past(wdata) & 8'h1F)));

    // R12: a seconds write wins over any tick in the same cycle.
    p_write_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0) |=> (st.sec == $past(wdata)));

    // R5: minutes only move when seconds were at 59 (or on a write).
    p_min_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && st.sec[6:0] != 7'h59) |=> $stable(st.min));
endmodule

bind bcd_calendar cal_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .halted    (halted),
    .sec_pulse (sec_pulse),
    .st        (r_q)
);

// File: tb/bcd_calendar_test.sv
module bcd_calendar_test;
    localparam int SUB = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       halted;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] m [0:6];
    int         m_phase;

    always #4 clk = ~clk;

    bcd_calendar #(.SUB_TICKS(SUB)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .halted(halted)
    );

    function automatic int b2i(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] i2b(input int i);
        return 8'(((i / 10) << 4) | (i % 10));
    endfunction

    function automatic logic [7:0] mask_of(input int a);
        case (a)
            1, 2:    return 8'h7F;
            3:       return 8'h07;
            4:       return 8'h3F;
            5:       return 8'h1F;
            0, 6:    return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic int days_in(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    task automatic model_second();
        int s, mi, h, dw, dt, mo, y;
        bit pm, m12, day;
        s  = b2i({1'b0, m[0][6:0]});
        mi = b2i(m[1]);
        m12 = m[2][6];
        pm  = m[2][5];
        h  = m12 ? b2i({3'b000, m[2][4:0]}) : b2i({2'b00, m[2][5:0]});
        dw = int'(m[3]);
        dt = b2i(m[4]);
        mo = b2i(m[5]);
        y  = b2i(m[6]);
        day = 0;
        s++;
        if (s == 60) begin
            s = 0; mi++;
            if (mi == 60) begin
                mi = 0;
                if (m12) begin
                    if (h == 12) h = 1;
                    else if (h == 11) begin h = 12; day = pm; pm = !pm; end
                    else h++;
                end else begin
                    if (h == 23) begin h = 0; day = 1; end else h++;
                end
                if (day) begin
                    dw = (dw == 7) ? 1 : dw + 1;
                    if (dt >= days_in(mo, y)) begin
                        dt = 1; mo++;
                        if (mo > 12) begin mo = 1; y = (y + 1) % 100; end
                    end else dt++;
                end
            end
        end
        m[0] = i2b(s);
        m[1] = i2b(mi);
        m[2] = m12 ? {1'b0, 1'b1, pm, i2b(h)[4:0]} : {2'b00, i2b(h)[5:0]};
        m[3] = 8'(dw);
        m[4] = i2b(dt);
        m[5] = i2b(mo);
        m[6] = i2b(y);
    endtask

    task automatic model_tick();
        if (m[0][7]) return;
        m_phase++;
        if (m_phase < SUB) return;
        m_phase = 0;
        model_second();
    endtask

    // One clock cycle, driven at the falling edge.
    task automatic cyc(input bit w, input int a, input logic [7:0] d, input bit t);
        wr_en = w; addr = 3'(a); wdata = d; tick = t;
        @(posedge clk);
        if (w) begin
            if (a < 7) m[a] = d & mask_of(a);
            if (a == 0) m_phase = 0;
        end else if (t) model_tick();
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic cmp_all(input string tag);
        for (int i = 0; i < 8; i++) begin
            addr = 3'(i);
            #1;
            chk($sformatf("%s reg%0d", tag, i), rdata, (i < 7) ? m[i] : 8'h00);
        end
        chk({tag, " halted"}, {7'd0, halted}, {7'd0, m[0][7]});
    endtask

    task automatic set_all(input logic [7:0] s, mi, h, dw, dt, mo, y);
        cyc(1, 0, s, 0); cyc(1, 1, mi, 0); cyc(1, 2, h, 0);
        cyc(1, 3, dw, 0); cyc(1, 4, dt, 0); cyc(1, 5, mo, 0); cyc(1, 6, y, 0);
    endtask

    task automatic one_sec();
        for (int k = 0; k < SUB; k++) cyc(0, 0, 8'h00, 1);
    endtask

    initial begin
        m[0] = 8'h00; m[1] = 8'h00; m[2] = 8'h00; m[3] = 8'h01;
        m[4] = 8'h01; m[5] = 8'h01; m[6] = 8'h00; m_phase = 0;
        void'($urandom(32'd1307));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_all("R1 reset");

        // R2: masks and address 7
        for (int a = 0; a < 8; a++) cyc(1, a, 8'hFF, 0);
        cmp_all("R2 mask");
        set_all(8'h10, 8'h20, 8'h08, 8'h03, 8'h15, 8'h06, 8'h24);
        cmp_all("R2 write");

        // R3: one second per SUB ticks
        for (int k = 0; k < SUB - 1; k++) cyc(0, 0, 8'h00, 1);
        cmp_all("R3 partial");
        cyc(0, 0, 8'h00, 1);
        cmp_all("R3 step");

        // R4: halt
        cyc(1, 0, 8'h85, 0);
        for (int k = 0; k < 3 * SUB; k++) cyc(0, 0, 8'h00, 1);
        cmp_all("R4 halted");
        cyc(1, 0, 8'h05, 0);
        one_sec();
        cmp_all("R4 resumed");

        // R5/R6/R10: 24-hour day end, weekday 7
        set_all(8'h59, 8'h59, 8'h23, 8'h07, 8'h30, 8'h04, 8'h23);
        one_sec();
        cmp_all("R5 R6 R8 R10 24h end of April");

        // R7: 12-hour transitions
        set_all(8'h59, 8'h59, 8'h51, 8'h02, 8'h10, 8'h03, 8'h10);
        one_sec();
        cmp_all("R7 11AM to 12PM");
        set_all(8'h59, 8'h59, 8'h72, 8'h02, 8'h10, 8'h03, 8'h10);
        one_sec();
        cmp_all("R7 12PM to 1PM");
        set_all(8'h59, 8'h59, 8'h71, 8'h02, 8'h31, 8'h01, 8'h10);
        one_sec();
        cmp_all("R7 R8 11PM to 12AM end of Jan");

        // R9: February in leap and non-leap years
        set_all(8'h59, 8'h59, 8'h23, 8'h04, 8'h28, 8'h02, 8'h24);
        one_sec();
        cmp_all("R9 leap 28");
        set_all(8'h59, 8'h59, 8'h23, 8'h04, 8'h28, 8'h02, 8'h25);
        one_sec();
        cmp_all("R9 common 28");
        set_all(8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h96);
        one_sec();
        cmp_all("R9 leap 29");

        // R11: year end of 99
        set_all(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
        one_sec();
        cmp_all("R11 year wrap");

        // R12: write collides with the completing tick; seconds write clears phase
        set_all(8'h20, 8'h00, 8'h10, 8'h01, 8'h01, 8'h01, 8'h00);
        for (int k = 0; k < SUB - 1; k++) cyc(0, 0, 8'h00, 1);
        cyc(1, 1, 8'h05, 1);
        cmp_all("R12 collision");
        cyc(0, 0, 8'h00, 1);
        cmp_all("R12 after collision");
        for (int k = 0; k < SUB - 2; k++) cyc(0, 0, 8'h00, 1);
        cyc(1, 0, 8'h40, 0);
        for (int k = 0; k < SUB - 1; k++) cyc(0, 0, 8'h00, 1);
        cmp_all("R12 phase cleared");
        cyc(0, 0, 8'h00, 1);
        cmp_all("R12 full second");

        // Random boundary-heavy runs (R3..R11)
        for (int it = 0; it < 60; it++) begin
            int mo, y, dt, h, nt;
            bit m12, pm;
            logic [7:0] hb;
            mo  = $urandom_range(1, 12);
            y   = $urandom_range(0, 99);
            dt  = days_in(mo, y) - $urandom_range(0, 1);
            m12 = $urandom_range(0, 1);
            pm  = $urandom_range(0, 1);
            if (m12) begin
                h  = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 12) : 11 + $urandom_range(0, 1);
                hb = {1'b0, 1'b1, pm, i2b(h)[4:0]};
            end else begin
                h  = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 23) : 22 + $urandom_range(0, 1);
                hb = {2'b00, i2b(h)[5:0]};
            end
            set_all({($urandom_range(0, 7) == 0), i2b(58 + $urandom_range(0, 1))[6:0]},
                    i2b(59 - $urandom_range(0, 1)), hb, 8'($urandom_range(1, 7)),
                    i2b(dt), i2b(mo), i2b(y));
            nt = $urandom_range(SUB, 8 * SUB);
            for (int k = 0; k < nt; k++) begin
                if ($urandom_range(0, 15) == 0)
                    cyc(1, 3, 8'($urandom_range(1, 7)), $urandom_range(0, 1));
                else
                    cyc(0, 0, 8'h00, $urandom_range(0, 3) != 0);
            end
            cmp_all($sformatf("R3-model random %0d", it));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule